// File: doc/BRIEF.md
# NAND Command and Address Latch Bridge

This block sits between a simple single-request bus and a bank of 8-bit NAND flash devices. Every bus access becomes one NAND bus cycle, and the address of the access decides what kind of cycle it is. One address bit marks a command latch cycle and another marks an address latch cycle. If neither bit is set, the access is a plain data cycle. Address fields also pick the core chip select and the device behind it, so each device sits in its own window within the map. A multi-byte flash address is sent as a run of single-byte writes to the address-latch window.

A small register space sits beside the flash windows. It has:
- a control word, holding one NAND-mode enable bit per core chip select and three 4-bit timing counts (setup, strobe and hold);
- a status word, whose ready bit follows the shared wire-AND ready/busy line through a two-flop synchronizer;
- a fixed revision word.

The bus acknowledge is held back until the hold phase of the flash cycle has finished. Software can therefore issue the next access as soon as it sees the acknowledge.

Top module: `nlb_bridge`

## Requirements
- R1: A write to the flash window with address bit 4 set is a command cycle. CLE is high and ALE is low. The I/O bus carries bus_wdata[7:0] and stays stable while write enable is low.
- R2: A write with address bit 3 set and bit 4 clear is a single address cycle, with ALE high, CLE low and bus_wdata[7:0] on the I/O bus.
- R3: An access with bits 4 and 3 both clear is a data cycle. A write drives bus_wdata[7:0]. A read pulses read enable and returns the I/O input in bus_rdata[7:0], sampled in the last strobe cycle, with bits 31:8 zero.
- R4: Chip-enable line k = 2*cs + dev is driven low during a flash cycle. Here cs is address bits 13:12 and dev is address bit 9. At most one enable is low at any time, and none is low outside a cycle.
- R5: Control bits 3:0 enable flash cycles on core chip selects 0 to 3; bit i serves chip select i. An access to a chip select whose bit is clear produces no chip enable and no strobe. It is acknowledged in the next cycle and returns zero.
- R6: Control bits 11:8, 15:12 and 19:16 hold the setup (S), strobe (T) and hold (H) counts. A flash cycle keeps a chip enable low for S+T+H+3 cycles, with the strobe low for exactly T+1 of them. bus_ack is a one-cycle pulse, S+T+H+3 cycles after the request is sampled. Write and read enable are never low together.
- R7: Status register (address 0x8004) bit 0 shows the ready input through two flops. A request sampled at the second clock edge after a change still returns the old value. A request made a few cycles later returns the new value.
- R8: The revision register (address 0x8008) reads 0x0102: major number 1 in bits 15:8 and minor number 2 in bits 7:0.
- R9: The control register (address 0x8000) reads back bits 19:8 and 3:0 as written. All other bits read zero. After reset the register reads zero.
- R10: A write with both address bits 4 and 3 set is a command cycle, with CLE high and ALE low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | One-cycle access request, accepted only when idle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address; bit 15 selects register space |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| nand_ce_n | output | 8 | Active-low chip enables, one per device |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_io_out | output | 8 | I/O bus output byte |
| nand_io_oe | output | 1 | I/O bus output enable |
| nand_io_in | input | 8 | I/O bus input byte |
| nand_rdy | input | 1 | Shared wire-AND ready/busy line |

## Verification
A phase counter that loads the wrong field, or misses its terminal count, shows up on the first flash access. The strobe width or the chip-enable window differs from T+1 or S+T+H+3 cycles, and the acknowledge arrives early or late. A wrong stored cycle type or device index shows in the CLE, ALE or chip-enable pattern sampled during that access's strobe. A wrong synchronizer depth shows up only when a status read is issued right after the ready line moves, so the bench reads status at exactly that point.

// File: rtl/nlb_pkg.sv
package nlb_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_DONE   = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        K_DATA = 2'd0,
        K_ADDR = 2'd1,
        K_CMD  = 2'd2
    } kind_e;
endpackage

// File: rtl/nlb_sync.sv
module nlb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/nlb_decode.sv
module nlb_decode
    import nlb_pkg::*;
#(
    parameter int AW        = 16,
    parameter int REG_BIT   = 15,
    parameter int CLE_BIT   = 4,
    parameter int ALE_BIT   = 3,
    parameter int DEV_SHIFT = 9,
    parameter int DEV_W     = 1,
    parameter int CS_LSB    = 12,
    parameter int CS_W      = 2,
    localparam int CEW      = CS_W + DEV_W
) (
    input  logic [AW-1:0]   addr,
    output logic            is_reg,
    output logic [1:0]      reg_idx,
    output kind_e           kind,
    output logic [CS_W-1:0] cs,
    output logic [CEW-1:0]  ce_idx
);
    logic unused_addr;
    assign unused_addr = ^addr;

    always_comb begin
        is_reg  = addr[REG_BIT];
        reg_idx = addr[3:2];
        cs      = addr[CS_LSB +: CS_W];
        ce_idx  = {addr[CS_LSB +: CS_W], addr[DEV_SHIFT +: DEV_W]};
        if (addr[CLE_BIT])      kind = K_CMD;
        else if (addr[ALE_BIT]) kind = K_ADDR;
        else                    kind = K_DATA;
    end
endmodule

// File: rtl/nlb_bridge.sv
module nlb_bridge
    import nlb_pkg::*;
#(
    parameter int AW        = 16,
    parameter int REG_BIT   = 15,
    parameter int CLE_BIT   = 4,
    parameter int ALE_BIT   = 3,
    parameter int DEV_SHIFT = 9,
    parameter int DEV_W     = 1,
    parameter int CS_LSB    = 12,
    parameter int CS_W      = 2,
    parameter int CNT_W     = 4,
    parameter int SYNC_LEN  = 2,
    parameter int REV_MAJOR = 1,
    parameter int REV_MINOR = 2,
    localparam int NCS      = 1 << CS_W,
    localparam int NDEV     = 1 << DEV_W,
    localparam int NCE      = NCS * NDEV,
    localparam int CEW      = CS_W + DEV_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_req,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic           bus_ack,
    output logic [31:0]    bus_rdata,
    output logic [NCE-1:0] nand_ce_n,
    output logic           nand_cle,
    output logic           nand_ale,
    output logic           nand_we_n,
    output logic           nand_re_n,
    output logic [7:0]     nand_io_out,
    output logic           nand_io_oe,
    input  logic [7:0]     nand_io_in,
    input  logic           nand_rdy
);
    localparam int SU_LSB = 8;
    localparam int ST_LSB = SU_LSB + CNT_W;
    localparam int HD_LSB = SU_LSB + 2 * CNT_W;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             rd;
        kind_e            kind;
        logic [CEW-1:0]   ce;
        logic [7:0]       wbyte;
        logic [31:0]      rdata;
        logic [NCS-1:0]   en;
        logic [CNT_W-1:0] t_su;
        logic [CNT_W-1:0] t_st;
        logic [CNT_W-1:0] t_hd;
    } st_t;

    st_t st_d, st_q;

    logic            dec_is_reg;
    logic [1:0]      dec_reg_idx;
    kind_e           dec_kind;
    logic [CS_W-1:0] dec_cs;
    logic [CEW-1:0]  dec_ce;
    logic            rdy_s;
    logic [31:0]     reg_rd;
    logic [31:0]     ctrl_view;
    logic            active;
    logic            unused_wdata;

    assign unused_wdata = ^bus_wdata;

    nlb_decode #(
        .AW(AW), .REG_BIT(REG_BIT), .CLE_BIT(CLE_BIT), .ALE_BIT(ALE_BIT),
        .DEV_SHIFT(DEV_SHIFT), .DEV_W(DEV_W), .CS_LSB(CS_LSB), .CS_W(CS_W)
    ) u_dec (
        .addr    (bus_addr),
        .is_reg  (dec_is_reg),
        .reg_idx (dec_reg_idx),
        .kind    (dec_kind),
        .cs      (dec_cs),
        .ce_idx  (dec_ce)
    );

    nlb_sync #(.STAGES(SYNC_LEN)) u_rdy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nand_rdy),
        .q     (rdy_s)
    );

    always_comb begin
        ctrl_view = '0;
        ctrl_view[NCS-1:0]         = st_q.en;
        ctrl_view[SU_LSB +: CNT_W] = st_q.t_su;
        ctrl_view[ST_LSB +: CNT_W] = st_q.t_st;
        ctrl_view[HD_LSB +: CNT_W] = st_q.t_hd;
        case (dec_reg_idx)
            2'd0:    reg_rd = ctrl_view;
            2'd1:    reg_rd = {31'd0, rdy_s};
            2'd2:    reg_rd = {16'd0, 8'(REV_MAJOR), 8'(REV_MINOR)};
            default: reg_rd = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_IDLE: begin
                if (bus_req) begin
                    if (dec_is_reg) begin
                        st_d.ph = PH_DONE;
                        if (bus_we) begin
                            if (dec_reg_idx == 2'd0) begin
                                st_d.en   = bus_wdata[NCS-1:0];
                                st_d.t_su = bus_wdata[SU_LSB +: CNT_W];
                                st_d.t_st = bus_wdata[ST_LSB +: CNT_W];
                                st_d.t_hd = bus_wdata[HD_LSB +: CNT_W];
                            end
                        end else begin
                            st_d.rdata = reg_rd;
                        end
                    end else if (!st_q.en[dec_cs]) begin
                        st_d.ph    = PH_DONE;
                        st_d.rdata = '0;
                    end else begin
                        st_d.ph    = PH_SETUP;
                        st_d.cnt   = st_q.t_su;
                        st_d.rd    = !bus_we;
                        st_d.kind  = bus_we ? dec_kind : K_DATA;
                        st_d.ce    = dec_ce;
                        st_d.wbyte = bus_wdata[7:0];
                    end
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_STROBE;
                    st_d.cnt = st_q.t_st;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_HOLD;
                    st_d.cnt = st_q.t_hd;
                    if (st_q.rd) st_d.rdata = {24'd0, nand_io_in};
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == '0) st_d.ph = PH_DONE;
                else                st_d.cnt = st_q.cnt - 1'b1;
            end
            PH_DONE: st_d.ph = PH_IDLE;
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.ph == PH_SETUP) || (st_q.ph == PH_STROBE) ||
                    (st_q.ph == PH_HOLD);

    generate
        for (genvar i = 0; i < NCE; i++) begin : g_ce
            assign nand_ce_n[i] = !(active && (st_q.ce == CEW'(i)));
        end
    endgenerate

    assign nand_cle    = active && (st_q.kind == K_CMD);
    assign nand_ale    = active && (st_q.kind == K_ADDR);
    assign nand_we_n   = !((st_q.ph == PH_STROBE) && !st_q.rd);
    assign nand_re_n   = !((st_q.ph == PH_STROBE) && st_q.rd);
    assign nand_io_out = st_q.wbyte;
    assign nand_io_oe  = active && !st_q.rd;
    assign bus_ack     = (st_q.ph == PH_DONE);
    assign bus_rdata   = st_q.rdata;
endmodule

// File: rtl/nlb_bridge_chk.sv
module nlb_bridge_chk #(
    parameter int NCE = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_ack,
    input logic [NCE-1:0] nand_ce_n,
    input logic           nand_cle,
    input logic           nand_ale,
    input logic           nand_we_n,
    input logic           nand_re_n,
    input logic [7:0]     nand_io_out
);
    p_one_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nand_ce_n));

    p_strobe_has_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> (nand_ce_n != '1));

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    p_hold_after_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (nand_ce_n != '1));

    p_cle_ale_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_io_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && !$past(nand_we_n)) |-> $stable(nand_io_out));
endmodule

bind nlb_bridge nlb_bridge_chk #(.NCE(NCE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_ack     (bus_ack),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_io_out (nand_io_out)
);

// File: tb/nlb_bridge_bench.sv
module nlb_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic [7:0]  nand_ce_n;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out;
    logic [7:0]  nand_io_in = '0;
    logic        nand_rdy = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int we_cnt, re_cnt, act_cnt;
    logic       cap_cle, cap_ale;
    logic [7:0] cap_io, cap_ce;

    always #10 clk = ~clk;

    nlb_bridge u_nlb_bridge (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
        .nand_io_in(nand_io_in), .nand_rdy(nand_rdy)
    );

    always @(negedge clk) begin
        if (nand_ce_n != 8'hFF) act_cnt++;
        if (!nand_we_n) begin
            we_cnt++;
            cap_cle = nand_cle;
            cap_ale = nand_ale;
            cap_io  = nand_io_out;
            cap_ce  = nand_ce_n;
        end
        if (!nand_re_n) begin
            re_cnt++;
            cap_ce = nand_ce_n;
        end
    end

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [15:0] a,
                        input logic [31:0] d, output logic [31:0] rd,
                        output int lat);
        we_cnt = 0; re_cnt = 0; act_cnt = 0;
        cap_cle = 0; cap_ale = 0; cap_io = 0; cap_ce = 8'hFF;
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        lat = 0;
        while (!bus_ack && lat < 1000) begin
            lat++;
            @(negedge clk);
        end
        rd = bus_rdata;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] rd; int lat;
        check("R4 reset ce_n", {24'd0, nand_ce_n}, 32'hFF);
        check("R6 reset strobes", {30'd0, nand_we_n, nand_re_n}, 32'h3);
        check("R6 reset ack", {31'd0, bus_ack}, 32'h0);
        xfer(1'b0, 16'h8000, 0, rd, lat);
        check("R9 ctrl after reset", rd, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] rd; int lat;
        xfer(1'b1, 16'h8000, 32'hFFFF_FFFF, rd, lat);
        xfer(1'b0, 16'h8000, 0, rd, lat);
        check("R9 ctrl unused bits zero", rd, 32'h000F_FF0F);
        xfer(1'b0, 16'h8008, 0, rd, lat);
        check("R8 revision", rd, 32'h0000_0102);
        check("R8 register latency", lat, 0);
        xfer(1'b1, 16'h8000, 32'h0001_3205, rd, lat);
        xfer(1'b0, 16'h8000, 0, rd, lat);
        check("R9 ctrl readback", rd, 32'h0001_3205);
    endtask

    task automatic t_cmd;
        logic [31:0] rd; int lat;
        xfer(1'b1, 16'h0010, 32'hFFFF_FFA5, rd, lat);
        check("R1 cle", cap_cle, 1);
        check("R1 ale", cap_ale, 0);
        check("R1 opcode", cap_io, 8'hA5);
        check("R4 ce cs0 dev0", cap_ce, 8'hFE);
        check("R6 strobe width", we_cnt, 4);
        check("R6 ce window", act_cnt, 9);
        check("R6 ack latency", lat, 9);
    endtask

    task automatic t_addr;
        logic [31:0] rd; int lat;
        xfer(1'b1, 16'h0208, 32'h3C, rd, lat);
        check("R2 ale", cap_ale, 1);
        check("R2 cle", cap_cle, 0);
        check("R2 byte", cap_io, 8'h3C);
        check("R4 ce cs0 dev1", cap_ce, 8'hFD);
    endtask

    task automatic t_data;
        logic [31:0] rd; int lat;
        xfer(1'b1, 16'h2200, 32'h77, rd, lat);
        check("R3 data write latches", {30'd0, cap_cle, cap_ale}, 0);
        check("R3 data byte", cap_io, 8'h77);
        check("R4 ce cs2 dev1", cap_ce, 8'hDF);
        nand_io_in = 8'h9E;
        xfer(1'b0, 16'h2000, 0, rd, lat);
        check("R3 read strobe width", re_cnt, 4);
        check("R3 no write strobe on read", we_cnt, 0);
        check("R3 read data", rd, 32'h9E);
        check("R4 ce cs2 dev0", cap_ce, 8'hEF);
    endtask

    task automatic t_disabled;
        logic [31:0] rd; int lat;
        xfer(1'b1, 16'h1010, 32'h55, rd, lat);
        check("R5 no strobe", we_cnt, 0);
        check("R5 no ce", act_cnt, 0);
        check("R5 ack next cycle", lat, 0);
        nand_io_in = 8'hFF;
        xfer(1'b0, 16'h1000, 0, rd, lat);
        check("R5 read returns zero", rd, 0);
        check("R5 no read strobe", re_cnt, 0);
    endtask

    task automatic t_both;
        logic [31:0] rd; int lat;
        xfer(1'b1, 16'h0018, 32'h90, rd, lat);
        check("R10 cle", cap_cle, 1);
        check("R10 ale", cap_ale, 0);
    endtask

    task automatic t_timing;
        logic [31:0] rd; int lat;
        xfer(1'b1, 16'h8000, 32'h1, rd, lat);
        xfer(1'b1, 16'h0010, 32'h11, rd, lat);
        check("R6 min strobe", we_cnt, 1);
        check("R6 min latency", lat, 3);
        xfer(1'b1, 16'h8000, 32'h000F_FF01, rd, lat);
        xfer(1'b1, 16'h0000, 32'h22, rd, lat);
        check("R6 max strobe", we_cnt, 16);
        check("R6 max latency", lat, 48);
        check("R6 max ce window", act_cnt, 48);
    endtask

    task automatic t_status;
        logic [31:0] rd; int lat;
        nand_rdy = 1'b1;
        repeat (4) @(negedge clk);
        xfer(1'b0, 16'h8004, 0, rd, lat);
        check("R7 ready high", rd, 1);
        nand_rdy = 1'b0;
        xfer(1'b0, 16'h8004, 0, rd, lat);
        check("R7 two-flop delay keeps old value", rd, 1);
        repeat (3) @(negedge clk);
        xfer(1'b0, 16'h8004, 0, rd, lat);
        check("R7 busy seen", rd, 0);
        nand_rdy = 1'b1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_cmd();
        t_addr();
        t_data();
        t_disabled();
        t_both();
        t_status();
        t_timing();
        finish_run();
    end
endmodule